// File: doc/BRIEF.md
# Dual-Port Video Input Selector

This block sits at the input of a video encoding pipeline. It receives three byte-wide 4:2:2 pixel streams. The first is a primary port, whose line timing comes either from active-low horizontal and vertical sync strobes or from timing codes embedded in the byte stream. The second is an on-screen-display overlay port that only understands strobes. The third is a broadcast stream that has already been brought into the local clock domain and is timed by strobes. Every input is registered on a pixel clock edge chosen by a configuration bit.

Two independent select bits assign sources to two output paths. The video path takes either the broadcast stream or the primary port. The overlay path takes either the overlay port or the primary port. Each path delivers the active pixels of a line as a byte stream. Each byte is marked as valid and carries a tag saying whether it is a blue-difference, luma or red-difference sample. A start-of-line flag marks the first byte, and each path also reports vertical blanking and field.

With strobe timing, the active line has a fixed length of `LINE_BYTES`. It begins a programmable number of clocks after the horizontal strobe falls. With embedded timing, the line starts at a start-of-active-video code and ends at an end-of-active-video code. The code bytes themselves are never delivered as pixels.

Top module: `video_input_selector`

## Requirements
- R1: When `cfg_fall_edge` is 1, the input bytes and strobes are sampled on the falling clock edge. When it is 0, they are sampled on the rising edge.
- R2: When `cfg_ovl_sel` is 1, the overlay path carries the overlay port. When it is 0, the overlay path carries the primary port.
- R3: When `cfg_vid_sel` is 1, the video path carries the broadcast stream. When it is 0, the video path carries the primary port.
- R4: In strobe timing, clock 0 is the captured byte that first shows the horizontal strobe low. The bytes at clocks `cfg_act_delay` to `cfg_act_delay+LINE_BYTES-1` are delivered as valid, and no other bytes are.
- R5: Valid bytes are tagged in the repeating order Cb, Y, Cr, Y, with the code values Cb=0, Y=1 and Cr=2. The start-of-line flag is set only on the first byte of a line, and that byte is always tagged Cb.
- R6: In embedded timing (`cfg_prim_embedded`=1), a code is the byte sequence FF 00 00 XY, where bit 7 of XY is 1. Bit 4 of XY is 0 for start and 1 for end. A start code with bit 5 equal to 0 makes the next byte a Cb byte that opens the line. An end code closes the line. None of the four code bytes is ever delivered.
- R7: The protection bits XY[3:0] must equal {V^H, F^H, F^V, F^V^H}, where F is bit 6, V is bit 5 and H is bit 4. A code whose protection bits mismatch is ignored.
- R8: In embedded timing, field and vblank report the F and V bits of the last valid code. In strobe timing, vblank is 1 while the vertical strobe is low, and field is 0.
- R9: The overlay port never decodes embedded codes. An FF 00 00 80 sequence inside an overlay line is delivered as four ordinary pixel bytes.
- R10: While reset is asserted, both paths show no valid byte.
- R11: A start code with V=1 opens no line, so no valid bytes follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fall_edge | input | 1 | 1 = sample inputs on the falling edge |
| cfg_vid_sel | input | 1 | 1 = video path takes the broadcast stream |
| cfg_ovl_sel | input | 1 | 1 = overlay path takes the overlay port |
| cfg_prim_embedded | input | 1 | 1 = primary port uses embedded codes |
| cfg_act_delay | input | DLY_W | Clocks from the strobe fall to the first active byte |
| prim_data | input | 8 | Primary port bytes |
| prim_hs_n | input | 1 | Primary horizontal strobe, active low |
| prim_vs_n | input | 1 | Primary vertical strobe, active low |
| bcast_data | input | 8 | Broadcast stream bytes |
| bcast_hs_n | input | 1 | Broadcast horizontal strobe, active low |
| bcast_vs_n | input | 1 | Broadcast vertical strobe, active low |
| osd_data | input | 8 | Overlay port bytes |
| osd_hs_n | input | 1 | Overlay horizontal strobe, active low |
| osd_vs_n | input | 1 | Overlay vertical strobe, active low |
| vid_data | output | 8 | Video path byte |
| vid_valid | output | 1 | Video byte is an active pixel |
| vid_phase | output | 2 | Video sample tag (0 Cb, 1 Y, 2 Cr) |
| vid_sol | output | 1 | First byte of a video line |
| vid_vblank | output | 1 | Video path in vertical blanking |
| vid_field | output | 1 | Video path field |
| ovl_data | output | 8 | Overlay path byte |
| ovl_valid | output | 1 | Overlay byte is an active pixel |
| ovl_phase | output | 2 | Overlay sample tag (0 Cb, 1 Y, 2 Cr) |
| ovl_sol | output | 1 | First byte of an overlay line |
| ovl_vblank | output | 1 | Overlay path in vertical blanking |
| ovl_field | output | 1 | Overlay path field |

## Verification
The embedded assertions hold the following on every cycle:
- the sample-tag order within both decoders;
- the start-of-line flag always landing on a valid Cb byte;
- an end code always dropping the line at once;
- a code with bad protection, or a start code during vertical blanking, never arming a line.

Only the bench scenarios can show the following:
- which source each select bit actually routes to each path;
- where the active window falls relative to the strobe and the programmed delay;
- that the code bytes are stripped and that the overlay port passes code-like bytes through;
- which clock edge captured the data, shown by driving different values in the two half periods.

// File: rtl/video_input_selector.sv
module video_input_selector #(
  parameter int LINE_BYTES = 1440,
  parameter int DLY_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fall_edge,
  input  logic             cfg_vid_sel,
  input  logic             cfg_ovl_sel,
  input  logic             cfg_prim_embedded,
  input  logic [DLY_W-1:0] cfg_act_delay,
  input  logic [7:0]       prim_data,
  input  logic             prim_hs_n,
  input  logic             prim_vs_n,
  input  logic [7:0]       bcast_data,
  input  logic             bcast_hs_n,
  input  logic             bcast_vs_n,
  input  logic [7:0]       osd_data,
  input  logic             osd_hs_n,
  input  logic             osd_vs_n,
  output logic [7:0]       vid_data,
  output logic             vid_valid,
  output logic [1:0]       vid_phase,
  output logic             vid_sol,
  output logic             vid_vblank,
  output logic             vid_field,
  output logic [7:0]       ovl_data,
  output logic             ovl_valid,
  output logic [1:0]       ovl_phase,
  output logic             ovl_sol,
  output logic             ovl_vblank,
  output logic             ovl_field
);

  localparam int LW = $clog2(LINE_BYTES + 1);
  localparam int CW = ((DLY_W > LW) ? DLY_W : LW) + 1;
  localparam logic [CW-1:0] LINE_CW = CW'(LINE_BYTES);
  localparam logic [1:0] PH_CB = 2'd0;
  localparam logic [1:0] PH_Y  = 2'd1;
  localparam logic [1:0] PH_CR = 2'd2;
  localparam logic [29:0] CAP_RST = {3{8'h00, 2'b11}};

  function automatic logic [1:0] tag_of(input logic [1:0] n);
    return (n == 2'd0) ? PH_CB : (n[0] ? PH_Y : PH_CR);
  endfunction

  // Input capture: both edges sampled, cfg picks which one feeds the pipeline
  logic [29:0] raw, neg_q, cap;
  assign raw = {osd_data, osd_hs_n, osd_vs_n,
                bcast_data, bcast_hs_n, bcast_vs_n,
                prim_data, prim_hs_n, prim_vs_n};

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) neg_q <= CAP_RST;
    else        neg_q <= raw;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap <= CAP_RST;
    else        cap <= cfg_fall_edge ? neg_q : raw;

  logic [CW-1:0] dly_ext;
  assign dly_ext = {{(CW-DLY_W){1'b0}}, cfg_act_delay};

  // Strobe-timed engines: 0 primary, 1 broadcast, 2 overlay
  for (genvar g = 0; g < 3; g++) begin : g_strobe
    logic [7:0]    o_data;
    logic          o_valid, o_sol, o_vb;
    logic [1:0]    o_phase;
    logic          hs_q, run, fall, act;
    logic [CW-1:0] cnt, k, rel;

    assign fall = hs_q & ~cap[g*10+1];
    assign k    = fall ? '0 : cnt;
    assign rel  = k - dly_ext;
    assign act  = (fall | run) && (k >= dly_ext) && (rel < LINE_CW);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hs_q <= 1'b1; run <= 1'b0; cnt <= '0;
        o_data <= '0; o_valid <= 1'b0; o_sol <= 1'b0; o_vb <= 1'b0; o_phase <= PH_CB;
      end else begin
        hs_q <= cap[g*10+1];
        if (fall) begin
          run <= 1'b1;
          cnt <= CW'(1);
        end else if (run && cnt != '1) begin
          cnt <= cnt + 1'b1;
        end
        o_data  <= cap[g*10+2 +: 8];
        o_valid <= act;
        o_sol   <= act && (rel == '0);
        o_phase <= tag_of(rel[1:0]);
        o_vb    <= ~cap[g*10];
      end

    // R5
    strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && $past(o_valid) && $past(o_phase) == PH_CB) |-> o_phase == PH_Y);
  end

  // Embedded-code decoder on the primary port
  logic [7:0] w1, w2, w3;
  logic       e_act, e_pend, e_f, e_v;
  logic [1:0] e_skip, e_ph;
  logic [7:0] e_data;
  logic       e_valid, e_sol, e_vb, e_fld;
  logic [1:0] e_phase;
  logic [7:0] pd;
  logic       code_pre, prot_ok, code_hit, eav_hit, sav_hit, e_go, slot_on;

  assign pd       = cap[9:2];
  assign code_pre = (w3 == 8'hFF) && (w2 == 8'h00) && (w1 == 8'h00) && pd[7];
  assign prot_ok  = pd[3:0] == {pd[5]^pd[4], pd[6]^pd[4], pd[6]^pd[5], pd[6]^pd[5]^pd[4]};
  assign code_hit = code_pre & prot_ok;
  assign eav_hit  = code_hit & pd[4];
  assign sav_hit  = code_hit & ~pd[4];
  assign e_go     = e_pend && (e_skip == 2'd0);
  assign slot_on  = (e_act | e_go) & ~code_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w1 <= '0; w2 <= '0; w3 <= '0;
      e_act <= 1'b0; e_pend <= 1'b0; e_skip <= '0; e_ph <= '0;
      e_f <= 1'b0; e_v <= 1'b0;
      e_data <= '0; e_valid <= 1'b0; e_sol <= 1'b0; e_vb <= 1'b0; e_fld <= 1'b0;
      e_phase <= PH_CB;
    end else begin
      w1 <= pd; w2 <= w1; w3 <= w2;
      if (eav_hit) begin
        e_act  <= 1'b0;
        e_pend <= 1'b0;
      end else if (sav_hit) begin
        e_act  <= 1'b0;
        e_pend <= ~pd[5];
        e_skip <= 2'd3;
        e_ph   <= 2'd0;
      end else begin
        if (e_go) begin
          e_act  <= 1'b1;
          e_pend <= 1'b0;
        end else if (e_pend) begin
          e_skip <= e_skip - 1'b1;
        end
        if (slot_on) e_ph <= e_ph + 1'b1;
      end
      if (code_hit) begin
        e_f <= pd[6];
        e_v <= pd[5];
      end
      e_data  <= w3;
      e_valid <= slot_on;
      e_sol   <= slot_on & ~e_act;
      e_phase <= tag_of(e_ph);
      e_vb    <= e_v;
      e_fld   <= e_f;
    end

  // R6
  eav_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eav_hit |=> (!e_valid && !e_act && !e_pend));
  // R7
  bad_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_pre && !prot_ok && !e_pend && !e_act) |=> (!e_pend && !e_act));
  // R11
  vblank_sav_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_hit && pd[5]) |=> (!e_pend && !e_act));
  // R5
  emb_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_valid && $past(e_valid) && $past(e_phase) == PH_CB) |-> e_phase == PH_Y);

  // Primary source and path routing
  logic [7:0] p_data;
  logic       p_valid, p_sol, p_vb, p_fld;
  logic [1:0] p_phase;

  assign p_data  = cfg_prim_embedded ? e_data  : g_strobe[0].o_data;
  assign p_valid = cfg_prim_embedded ? e_valid : g_strobe[0].o_valid;
  assign p_sol   = cfg_prim_embedded ? e_sol   : g_strobe[0].o_sol;
  assign p_phase = cfg_prim_embedded ? e_phase : g_strobe[0].o_phase;
  assign p_vb    = cfg_prim_embedded ? e_vb    : g_strobe[0].o_vb;
  assign p_fld   = cfg_prim_embedded & e_fld;

  assign vid_data   = cfg_vid_sel ? g_strobe[1].o_data  : p_data;
  assign vid_valid  = cfg_vid_sel ? g_strobe[1].o_valid : p_valid;
  assign vid_sol    = cfg_vid_sel ? g_strobe[1].o_sol   : p_sol;
  assign vid_phase  = cfg_vid_sel ? g_strobe[1].o_phase : p_phase;
  assign vid_vblank = cfg_vid_sel ? g_strobe[1].o_vb    : p_vb;
  assign vid_field  = cfg_vid_sel ? 1'b0                : p_fld;

  assign ovl_data   = cfg_ovl_sel ? g_strobe[2].o_data  : p_data;
  assign ovl_valid  = cfg_ovl_sel ? g_strobe[2].o_valid : p_valid;
  assign ovl_sol    = cfg_ovl_sel ? g_strobe[2].o_sol   : p_sol;
  assign ovl_phase  = cfg_ovl_sel ? g_strobe[2].o_phase : p_phase;
  assign ovl_vblank = cfg_ovl_sel ? g_strobe[2].o_vb    : p_vb;
  assign ovl_field  = cfg_ovl_sel ? 1'b0                : p_fld;

  // R5
  vid_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vid_sol |-> (vid_valid && vid_phase == PH_CB));
  // R5
  ovl_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_sol |-> (ovl_valid && ovl_phase == PH_CB));

endmodule

// File: tb/tb_video_input_selector.sv
`timescale 1ns/1ps
module tb_video_input_selector;
  localparam int LB = 8;
  localparam int DW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cfg_fall_edge, cfg_vid_sel, cfg_ovl_sel, cfg_prim_embedded;
  logic [DW-1:0] cfg_act_delay;
  logic [7:0] prim_data, bcast_data, osd_data;
  logic prim_hs_n, prim_vs_n, bcast_hs_n, bcast_vs_n, osd_hs_n, osd_vs_n;
  logic [7:0] vid_data, ovl_data;
  logic vid_valid, vid_sol, vid_vblank, vid_field, ovl_valid, ovl_sol, ovl_vblank, ovl_field;
  logic [1:0] vid_phase, ovl_phase;

  video_input_selector #(.LINE_BYTES(LB), .DLY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_fall_edge(cfg_fall_edge), .cfg_vid_sel(cfg_vid_sel),
    .cfg_ovl_sel(cfg_ovl_sel), .cfg_prim_embedded(cfg_prim_embedded), .cfg_act_delay(cfg_act_delay),
    .prim_data(prim_data), .prim_hs_n(prim_hs_n), .prim_vs_n(prim_vs_n),
    .bcast_data(bcast_data), .bcast_hs_n(bcast_hs_n), .bcast_vs_n(bcast_vs_n),
    .osd_data(osd_data), .osd_hs_n(osd_hs_n), .osd_vs_n(osd_vs_n),
    .vid_data(vid_data), .vid_valid(vid_valid), .vid_phase(vid_phase), .vid_sol(vid_sol),
    .vid_vblank(vid_vblank), .vid_field(vid_field),
    .ovl_data(ovl_data), .ovl_valid(ovl_valid), .ovl_phase(ovl_phase), .ovl_sol(ovl_sol),
    .ovl_vblank(ovl_vblank), .ovl_field(ovl_field));

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_tag = "R10";
  logic [10:0] vq[$];
  logic [10:0] oq[$];
  string vt[$];
  string ot[$];

  function automatic logic [1:0] ph(input int r);
    return (r % 4 == 0) ? 2'd0 : ((r % 2 == 1) ? 2'd1 : 2'd2);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    logic [10:0] it;
    string tg;
    if (rst_n && !done) begin
      if (vid_valid) begin
        if (vq.size() == 0) chk(0, cur_tag, "unexpected video byte", vid_data, 0);
        else begin
          it = vq.pop_front(); tg = vt.pop_front();
          chk({vid_data, vid_phase, vid_sol} == it, tg, "video byte", {vid_data, vid_phase, vid_sol}, it);
        end
      end
      if (ovl_valid) begin
        if (oq.size() == 0) chk(0, cur_tag, "unexpected overlay byte", ovl_data, 0);
        else begin
          it = oq.pop_front(); tg = ot.pop_front();
          chk({ovl_data, ovl_phase, ovl_sol} == it, tg, "overlay byte", {ovl_data, ovl_phase, ovl_sol}, it);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic expect_b(input bit v, input bit o, input logic [7:0] d, input logic [1:0] p,
                          input bit s, input string t);
    if (v) begin vq.push_back({d, p, s}); vt.push_back(t); end
    if (o) begin oq.push_back({d, p, s}); ot.push_back(t); end
  endtask

  task automatic set_port(input int port, input logic [7:0] d, input logic hs);
    case (port)
      0: begin prim_data = d; prim_hs_n = hs; end
      1: begin bcast_data = d; bcast_hs_n = hs; end
      default: begin osd_data = d; osd_hs_n = hs; end
    endcase
  endtask

  // mode 0 plain, 1 decoy in second half expecting first-half value, 2 expecting decoy
  task automatic strobe_line(input int port, input int dly, input logic [7:0] base, input bit to_v,
                             input bit to_o, input int mode, input bit inject, input string t);
    cfg_act_delay = dly[DW-1:0];
    tick(); set_port(port, 8'h00, 1'b1);
    for (int k = 0; k < dly + LB + 4; k++) begin
      logic [7:0] b;
      b = base + 8'(k);
      if (inject && k >= dly && k < dly + 4)
        case (k - dly) 0: b = 8'hFF; 1: b = 8'h00; 2: b = 8'h00; default: b = 8'h80; endcase
      tick(); set_port(port, b, (k < 2) ? 1'b0 : 1'b1);
      if (k >= dly && k < dly + LB) expect_b(to_v, to_o, (mode == 2) ? ~b : b, ph(k - dly), k == dly, t);
      if (mode != 0) begin #10; set_port(port, ~b, (k < 2) ? 1'b0 : 1'b1); end
    end
    tick(); set_port(port, 8'h00, 1'b1);
  endtask

  task automatic settle(input string t);
    repeat (12) tick();
    chk(vq.size() == 0, t, "video items outstanding", vq.size(), 0);
    chk(oq.size() == 0, t, "overlay items outstanding", oq.size(), 0);
  endtask

  task automatic eb(input logic [7:0] b);
    tick(); prim_data = b;
  endtask

  task automatic code(input logic [7:0] xy);
    eb(8'hFF); eb(8'h00); eb(8'h00); eb(xy);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R10 watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_fall_edge = 0; cfg_vid_sel = 0; cfg_ovl_sel = 0; cfg_prim_embedded = 0;
    cfg_act_delay = '0;
    prim_data = 0; bcast_data = 0; osd_data = 0;
    prim_hs_n = 1; prim_vs_n = 1; bcast_hs_n = 1; bcast_vs_n = 1; osd_hs_n = 1; osd_vs_n = 1;
    repeat (3) @(negedge clk);
    // R10: no valid output while held in reset
    chk(!vid_valid && !ovl_valid, "R10", "valid during reset", {vid_valid, ovl_valid}, 0);
    tick(); rst_n = 1;
    repeat (4) tick();

    // R4 R5: primary strobe line, delay 3, seen on both paths (R2 R3 with selects 0)
    cur_tag = "R4";
    strobe_line(0, 3, 8'h20, 1, 1, 0, 0, "R4");
    settle("R4");
    // R4: zero delay boundary
    strobe_line(0, 0, 8'h30, 1, 1, 0, 0, "R4");
    settle("R4");
    // R4: maximum delay boundary
    strobe_line(0, 15, 8'h50, 1, 1, 0, 0, "R5");
    settle("R5");

    // R2 R9: overlay port on overlay path, embedded-looking bytes pass through
    cfg_ovl_sel = 1; cur_tag = "R2";
    strobe_line(2, 2, 8'h70, 0, 1, 0, 1, "R9");
    settle("R2");
    // R3: broadcast stream on video path
    cfg_vid_sel = 1; cur_tag = "R3";
    strobe_line(1, 1, 8'h90, 1, 0, 0, 0, "R3");
    settle("R3");
    // R2: overlay port line must not reach video path
    strobe_line(2, 4, 8'hA0, 0, 1, 0, 0, "R2");
    settle("R2");
    cfg_vid_sel = 0; cfg_ovl_sel = 0;

    // R6: embedded timing on primary
    cfg_prim_embedded = 1; cur_tag = "R6";
    repeat (4) eb(8'h10);
    code(8'h9D);
    repeat (3) eb(8'h10);
    code(8'h80);
    for (int i = 0; i < 10; i++) begin
      eb(8'h40 + 8'(i));
      expect_b(1, 1, 8'h40 + 8'(i), ph(i), i == 0, "R6");
    end
    code(8'h9D);
    repeat (4) eb(8'h10);
    settle("R6");
    chk(vid_field == 0 && vid_vblank == 0, "R8", "field/vblank after F0 V0 code", {vid_field, vid_vblank}, 0);

    // R7: corrupted start code is ignored
    cur_tag = "R7";
    code(8'h81);
    repeat (6) eb(8'h50);
    code(8'h9D);
    repeat (3) eb(8'h10);
    settle("R7");

    // R11: start code inside vertical blanking, F=1 V=1
    cur_tag = "R11";
    code(8'hEC);
    repeat (6) eb(8'h60);
    repeat (3) eb(8'h10);
    settle("R11");
    // R8: flags follow last valid code
    chk(vid_field == 1 && vid_vblank == 1, "R8", "field/vblank after F1 V1 code", {vid_field, vid_vblank}, 3);
    chk(ovl_field == 1 && ovl_vblank == 1, "R8", "overlay field/vblank", {ovl_field, ovl_vblank}, 3);
    code(8'h9D);
    repeat (4) eb(8'h10);
    chk(vid_field == 0 && vid_vblank == 0, "R8", "field/vblank back to 0", {vid_field, vid_vblank}, 0);

    // R8: strobe vblank and zero field
    cfg_prim_embedded = 0; eb(8'h00);
    prim_vs_n = 0;
    repeat (4) tick();
    chk(vid_vblank == 1 && vid_field == 0, "R8", "strobe vblank", {vid_vblank, vid_field}, 2);
    prim_vs_n = 1;
    repeat (4) tick();
    chk(vid_vblank == 0, "R8", "strobe vblank release", vid_vblank, 0);

    // R1: falling-edge capture sees first-half values, rising-edge sees decoys
    cfg_fall_edge = 1; cur_tag = "R1";
    repeat (3) tick();
    strobe_line(0, 2, 8'h11, 1, 1, 1, 0, "R1");
    settle("R1");
    cfg_fall_edge = 0;
    repeat (3) tick();
    strobe_line(0, 2, 8'h21, 1, 1, 2, 0, "R1");
    settle("R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule